// File: doc/BRIEF.md
# Seconds Countdown Alarm

This block counts down a 32-bit number of seconds and raises a sticky alarm flag when the count runs out. Software writes the number of seconds until the alarm into a load register, then sets a count-enable bit. Each one-cycle pulse on the 1 Hz tick input takes one off the remaining count while counting is enabled. The tick that moves the count from one to zero sets the pending flag, and the count then stays at zero.

The pending flag feeds two outputs. An interrupt output is gated by an interrupt-enable bit. A wake output for the power controller is gated by its own wakeup-enable bit. The flag stays set until software writes a one to it. Software reads the remaining count from its own register. A safe reload is: clear count-enable, write zero to the load register, write the new count, then enable counting again. Writing the load register while counting simply restarts the count from the new value.

Access goes through a simple memory-mapped bus of one cycle per transfer. Writes take effect at the clock edge that samples them. Read data appears on the cycle after the request.

Top module: `secs_countdown_alarm`

## Requirements
- R1: During and after synchronous reset, the remaining count, the load value, all enable bits, the pending flag, read data, `irq_o` and `wake_o` are zero.
- R2: A write to offset 0x20 sets both the remaining count and the load value to the written data. It takes priority over a tick in the same cycle, so the next tick starts counting down from the new value.
- R3: When bit 0 at offset 0x28 is 1, each cycle with `tick_1hz` high lowers a nonzero count by exactly one. With that bit at 0, or with the count at zero, a tick leaves the count unchanged.
- R4: The pending flag, bit 0 at offset 0x30, sets only on an enabled tick that takes the count from 1 to 0. Loading zero, or ticking while the count is already zero, does not set it.
- R5: Writing 1 to bit 0 at offset 0x30 clears the pending flag, and writing 0 there leaves it unchanged. If a set and a clear fall in the same cycle, the flag ends up set.
- R6: `irq_o` is high exactly when the pending flag is set and bit 0 at offset 0x2C is 1.
- R7: `wake_o` is high exactly when the pending flag is set and bit 0 at offset 0x50 is 1.
- R8: Read data appears on `bus_rdata` the cycle after a read request. Offset 0x24 returns the remaining count and 0x20 the load value. Offsets 0x28, 0x2C, 0x30 and 0x50 return their bit in bit 0 and zeros above it. Any other offset returns zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1hz | input | 1 | One-cycle pulse once per second |
| bus_sel | input | 1 | Bus transfer request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read request |
| irq_o | output | 1 | Interrupt request |
| wake_o | output | 1 | Wake request to the power controller |

## Verification
Two pairs of actions can land in the same cycle, and the bench drives each pair on the same clock edge. In the first pair, the tick that takes the count to zero arrives with a write-one-to-clear of the pending flag. The flag must read back as set, which shows that setting wins. In the second pair, a load write arrives with a tick. The remaining count must read back as exactly the loaded value, not one less. Sweeps over many load values and enable combinations check each result against a tick count and an enable mask that the bench works out itself.

// File: rtl/sca_pkg.sv
package sca_pkg;

    localparam int SCA_ADDR_W = 8;

    // Register offsets
    localparam logic [SCA_ADDR_W-1:0] OFS_LOAD    = 8'h20;
    localparam logic [SCA_ADDR_W-1:0] OFS_REMAIN  = 8'h24;
    localparam logic [SCA_ADDR_W-1:0] OFS_RUN     = 8'h28;
    localparam logic [SCA_ADDR_W-1:0] OFS_IRQ_EN  = 8'h2C;
    localparam logic [SCA_ADDR_W-1:0] OFS_PENDING = 8'h30;
    localparam logic [SCA_ADDR_W-1:0] OFS_WAKE_EN = 8'h50;

    // One-hot register select
    typedef struct packed {
        logic load;
        logic remain;
        logic run;
        logic irq_en;
        logic pending;
        logic wake_en;
    } sca_sel_t;

    // Enable and flag state
    typedef struct packed {
        logic run;
        logic irq_en;
        logic wake_en;
        logic pending;
    } sca_ctrl_t;

    function automatic sca_sel_t sca_decode(input logic [SCA_ADDR_W-1:0] addr);
        sca_sel_t s;
        s = '0;
        case (addr)
            OFS_LOAD:    s.load    = 1'b1;
            OFS_REMAIN:  s.remain  = 1'b1;
            OFS_RUN:     s.run     = 1'b1;
            OFS_IRQ_EN:  s.irq_en  = 1'b1;
            OFS_PENDING: s.pending = 1'b1;
            OFS_WAKE_EN: s.wake_en = 1'b1;
            default:     s         = '0;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/sca_down_counter.sv
module sca_down_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             tick,
    input  logic             run,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] load_q,
    output logic             expire
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic             step;
    logic [CNT_W-1:0] count_q;
    logic [CNT_W-1:0] load_r;

    // A load always wins over a tick in the same cycle.
    assign step   = run && tick && !load && (count_q != '0);
    assign expire = step && (count_q == ONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
            load_r  <= '0;
        end else if (load) begin
            count_q <= load_val;
            load_r  <= load_val;
        end else if (step) begin
            count_q <= count_q - ONE;
        end
    end

    assign count  = count_q;
    assign load_q = load_r;
endmodule

// File: rtl/sca_ctrl_regs.sv
module sca_ctrl_regs
    import sca_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      wr,
    input  logic      wr_run,
    input  logic      wr_irq_en,
    input  logic      wr_pending,
    input  logic      wr_wake_en,
    input  logic      wbit,
    input  logic      set_pending,
    output sca_ctrl_t ctrl
);
    sca_ctrl_t ctrl_q;
    logic      clear_hit;

    assign clear_hit = wr && wr_pending && wbit;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else begin
            if (wr && wr_run)     ctrl_q.run     <= wbit;
            if (wr && wr_irq_en)  ctrl_q.irq_en  <= wbit;
            if (wr && wr_wake_en) ctrl_q.wake_en <= wbit;
            // Setting has priority over a simultaneous clear.
            if (set_pending)      ctrl_q.pending <= 1'b1;
            else if (clear_hit)   ctrl_q.pending <= 1'b0;
        end
    end

    assign ctrl = ctrl_q;
endmodule

// File: rtl/sca_read_mux.sv
module sca_read_mux
    import sca_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_req,
    input  sca_sel_t          sel,
    input  logic [CNT_W-1:0]  count,
    input  logic [CNT_W-1:0]  load_q,
    input  sca_ctrl_t         ctrl,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] rdata_d;
    logic [DATA_W-1:0] rdata_q;

    always_comb begin
        rdata_d = '0;
        if (sel.load)    rdata_d = DATA_W'(load_q);
        if (sel.remain)  rdata_d = DATA_W'(count);
        if (sel.run)     rdata_d = DATA_W'(ctrl.run);
        if (sel.irq_en)  rdata_d = DATA_W'(ctrl.irq_en);
        if (sel.pending) rdata_d = DATA_W'(ctrl.pending);
        if (sel.wake_en) rdata_d = DATA_W'(ctrl.wake_en);
    end

    always_ff @(posedge clk) begin
        if (rst)         rdata_q <= '0;
        else if (rd_req) rdata_q <= rdata_d;
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/secs_countdown_alarm.sv
module secs_countdown_alarm
    import sca_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 32
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  tick_1hz,
    input  logic                  bus_sel,
    input  logic                  bus_wr,
    input  logic [SCA_ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0]     bus_wdata,
    output logic [DATA_W-1:0]     bus_rdata,
    output logic                  irq_o,
    output logic                  wake_o
);
    sca_sel_t         sel;
    sca_ctrl_t        ctrl;
    logic             wr_req;
    logic             rd_req;
    logic             load_hit;
    logic             clr_hit;
    logic             expire;
    logic [CNT_W-1:0] cnt_val;
    logic [CNT_W-1:0] load_val;

    assign sel      = sca_decode(bus_addr);
    assign wr_req   = bus_sel && bus_wr;
    assign rd_req   = bus_sel && !bus_wr;
    assign load_hit = wr_req && sel.load;
    assign clr_hit  = wr_req && sel.pending && bus_wdata[0];

    sca_down_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .load     (load_hit),
        .load_val (bus_wdata[CNT_W-1:0]),
        .tick     (tick_1hz),
        .run      (ctrl.run),
        .count    (cnt_val),
        .load_q   (load_val),
        .expire   (expire)
    );

    sca_ctrl_regs u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .wr          (wr_req),
        .wr_run      (sel.run),
        .wr_irq_en   (sel.irq_en),
        .wr_pending  (sel.pending),
        .wr_wake_en  (sel.wake_en),
        .wbit        (bus_wdata[0]),
        .set_pending (expire),
        .ctrl        (ctrl)
    );

    sca_read_mux #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_rd (
        .clk    (clk),
        .rst    (rst),
        .rd_req (rd_req),
        .sel    (sel),
        .count  (cnt_val),
        .load_q (load_val),
        .ctrl   (ctrl),
        .rdata  (bus_rdata)
    );

    assign irq_o  = ctrl.pending && ctrl.irq_en;
    assign wake_o = ctrl.pending && ctrl.wake_en;
endmodule

// File: rtl/sca_checker.sv
module sca_checker #(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              tick_1hz,
    input logic              load_hit,
    input logic              clr_hit,
    input logic              run,
    input logic              pending,
    input logic              irq_en,
    input logic              wake_en,
    input logic              irq_o,
    input logic              wake_o,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [CNT_W-1:0]  cnt_val
);
    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (cnt_val == '0) && !pending && !irq_o && !wake_o); // R1

    AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (rst)
        load_hit |=> cnt_val == $past(bus_wdata[CNT_W-1:0])); // R2

    AST_STEP_DOWN: assert property (@(posedge clk) disable iff (rst)
        (run && tick_1hz && !load_hit && cnt_val != '0) |=> cnt_val == $past(cnt_val) - CNT_W'(1)); // R3

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!load_hit && (!tick_1hz || !run)) |=> $stable(cnt_val)); // R3

    AST_EXPIRE_SETS: assert property (@(posedge clk) disable iff (rst)
        (run && tick_1hz && !load_hit && cnt_val == CNT_W'(1)) |=> pending); // R4

    AST_PEND_STICKY: assert property (@(posedge clk) disable iff (rst)
        (pending && !clr_hit) |=> pending); // R5

    AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> (irq_en && pending)); // R6

    AST_WAKE_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
        wake_o |-> (wake_en && pending)); // R7
endmodule

bind secs_countdown_alarm sca_checker #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_sca_chk (
    .clk       (clk),
    .rst       (rst),
    .tick_1hz  (tick_1hz),
    .load_hit  (load_hit),
    .clr_hit   (clr_hit),
    .run       (ctrl.run),
    .pending   (ctrl.pending),
    .irq_en    (ctrl.irq_en),
    .wake_en   (ctrl.wake_en),
    .irq_o     (irq_o),
    .wake_o    (wake_o),
    .bus_wdata (bus_wdata),
    .cnt_val   (cnt_val)
);

// File: tb/secs_countdown_alarm_tb_top.sv
module secs_countdown_alarm_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_1hz = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o;
    logic        wake_o;

    int checks = 0;
    int failures = 0;

    localparam logic [7:0] A_LOAD = 8'h20, A_REM = 8'h24, A_RUN = 8'h28,
                           A_IE = 8'h2C, A_PEND = 8'h30, A_WE = 8'h50;

    always #2 clk = ~clk;

    secs_countdown_alarm dut_i (
        .clk(clk), .rst(rst), .tick_1hz(tick_1hz), .bus_sel(bus_sel),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_o(irq_o), .wake_o(wake_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
        d = bus_rdata;
    endtask

    task automatic tick();
        @(negedge clk);
        tick_1hz = 1'b1;
        @(negedge clk);
        tick_1hz = 1'b0;
    endtask

    task automatic arm(input logic [31:0] n);
        wr(A_RUN, 32'd0);
        wr(A_LOAD, 32'd0);
        wr(A_PEND, 32'd1);
        wr(A_LOAD, n);
        wr(A_RUN, 32'd1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 irq", {31'd0, irq_o}, 32'd0);
        chk("R1 wake", {31'd0, wake_o}, 32'd0);
        chk("R1 rdata", bus_rdata, 32'd0);
        rst = 1'b0;
        rd(A_REM, v);  chk("R1 remain", v, 32'd0);
        rd(A_PEND, v); chk("R1 pending", v, 32'd0);
        rd(A_RUN, v);  chk("R1 run", v, 32'd0);

        // R8 control readback and unmapped
        wr(A_IE, 32'hFFFF_FFFF); rd(A_IE, v); chk("R8 ie readback", v, 32'd1);
        wr(A_WE, 32'hFFFF_FFFE); rd(A_WE, v); chk("R8 we readback", v, 32'd0);
        wr(A_IE, 32'd0);
        for (int a = 0; a < 256; a += 4) begin
            if (a != 'h20 && a != 'h24 && a != 'h28 && a != 'h2C && a != 'h30 && a != 'h50) begin
                wr(8'(a), 32'hA5A5_A5A5);
                rd(8'(a), v);
                chk("R8 unmapped", v, 32'd0);
            end
        end

        // Sweep: load n, enable pattern from n, count down to zero
        for (int n = 1; n <= 12; n++) begin
            logic ie, we;
            ie = n[0]; we = n[1];
            wr(A_IE, {31'd0, ie});
            wr(A_WE, {31'd0, we});
            arm(32'(n));
            rd(A_LOAD, v); chk("R2 load readback", v, 32'(n));
            for (int k = 1; k < n; k++) begin
                tick();
                rd(A_REM, v); chk("R3 step", v, 32'(n - k));
            end
            rd(A_PEND, v); chk("R4 not early", v, 32'd0);
            tick();
            rd(A_REM, v);  chk("R3 reached zero", v, 32'd0);
            rd(A_PEND, v); chk("R4 pending set", v, 32'd1);
            chk("R6 irq gate", {31'd0, irq_o}, {31'd0, ie});
            chk("R7 wake gate", {31'd0, wake_o}, {31'd0, we});
            wr(A_PEND, 32'd0);
            rd(A_PEND, v); chk("R5 write 0 keeps", v, 32'd1);
            wr(A_PEND, 32'd1);
            rd(A_PEND, v); chk("R5 w1c clears", v, 32'd0);
            chk("R6 irq low after clear", {31'd0, irq_o}, 32'd0);
            chk("R7 wake low after clear", {31'd0, wake_o}, 32'd0);
            tick();
            rd(A_REM, v);  chk("R3 hold at zero", v, 32'd0);
            rd(A_PEND, v); chk("R4 no refire at zero", v, 32'd0);
        end

        // R3 disabled ticks hold
        arm(32'd7);
        wr(A_RUN, 32'd0);
        tick(); tick();
        rd(A_REM, v); chk("R3 disabled hold", v, 32'd7);

        // R4 loading zero while running does not fire
        arm(32'd0);
        tick();
        rd(A_PEND, v); chk("R4 zero load no fire", v, 32'd0);

        // R2 maximum value
        arm(32'hFFFF_FFFF);
        tick();
        rd(A_REM, v); chk("R2 max step", v, 32'hFFFF_FFFE);

        // R2 load collides with tick: load wins
        arm(32'd5);
        @(negedge clk);
        tick_1hz = 1'b1; bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = A_LOAD; bus_wdata = 32'd9;
        @(negedge clk);
        tick_1hz = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0;
        rd(A_REM, v); chk("R2 load beats tick", v, 32'd9);
        tick();
        rd(A_REM, v); chk("R2 restart step", v, 32'd8);

        // R5 expiring tick collides with W1C: set wins
        wr(A_IE, 32'd1);
        arm(32'd1);
        @(negedge clk);
        tick_1hz = 1'b1; bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = A_PEND; bus_wdata = 32'd1;
        @(negedge clk);
        tick_1hz = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0;
        rd(A_PEND, v); chk("R5 set beats clear", v, 32'd1);
        chk("R6 irq on collision", {31'd0, irq_o}, 32'd1);

        // R8 read latency: data held until next read
        rd(A_REM, v);
        @(negedge clk);
        chk("R8 rdata held", bus_rdata, 32'd0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule